// File: doc/BRIEF.md
# SIMD Multiply-Accumulate Arithmetic Slice

This block is an arithmetic slice for filter, accumulator and counter datapaths. It has a signed multiplier of 27 by 18 bits, and a pre-adder in front of the multiplier that forms the sum or difference of two 27-bit inputs for symmetric filter taps. After the multiplier sits a 48-bit post-adder. A bypass bit routes a full 48-bit operand around the multiplier. The post-adder can run as one 48-bit lane, two 24-bit lanes or four 12-bit lanes, with no carry between lanes. A logic mode replaces the sum with one of ten bitwise functions.

The result register can be fed back as the second addend, so the slice accumulates. With a bypassed constant of +1 or -1 it counts. A masked pattern comparator watches the result register. It raises a match flag and an inverted-match flag one cycle later. Operands and controls pass through one input register and one output register, so a result appears two clock edges after its inputs. A clock enable holds every register. A synchronous reset clears all of them.

Top module: `mac_slice`

## Requirements
- R1: With bypass=0 and logic=0, the result register takes Z plus the product M, where M is the signed product of the pre-adder value and b_in, sign-extended to 48 bits. The result is written on the second rising edge after the inputs are applied.
- R2: The pre-adder value is a_in for pre_op 0 and 3, a_in+d_in for pre_op 1 and a_in-d_in for pre_op 2. It wraps to 27 bits.
- R3: With bypass=1, operand M is x_in taken unchanged instead of the product.
- R4: With acc_en=1, operand Z is the current p_out value. With acc_en=0, Z is y_in.
- R5: With sub=1, the post-adder produces Z minus M instead of Z plus M.
- R6: simd selects the lane split: 0 and 3 give one 48-bit lane, 1 gives two 24-bit lanes and 2 gives four 12-bit lanes. No carry or borrow crosses from one lane into the next.
- R7: carry_out[i] is the carry out of the lane whose top bit is 12*i+11. For subtraction it is 1 when no borrow occurs. Bits that do not end a lane read 0, and all bits read 0 in logic mode.
- R8: With logic=1, the result is a bitwise function of A=M and B=Z chosen by lfn. The codes are 0 AND, 1 OR, 2 XOR, 3 XNOR, 4 NAND, 5 NOR, 6 A AND NOT B, 7 NOT A AND B, 8 NOT A and 9 NOT B. Codes 10 to 15 give zero.
- R9: One edge after p_out updates, pat_hit is 1 when p_out equals pattern on every bit where mask is 0. pat_inv_hit is the same test against the inverse of pattern.
- R10: With bypass=1, acc_en=1, simd=0, logic=0 and x_in=1 held, p_out rises by one on each edge. With x_in all ones, it falls by one on each edge.
- R11: With ce=0, no register changes: p_out, carry_out and both flags keep their values.
- R12: rst=1 clears p_out, carry_out, both flags and the input stage on the next edge, whatever the value of ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| a_in | input | 27 | Pre-adder operand A (signed) |
| d_in | input | 27 | Pre-adder operand D (signed) |
| b_in | input | 18 | Multiplier operand (signed) |
| x_in | input | 48 | Wide operand used when the multiplier is bypassed |
| y_in | input | 48 | Wide second addend when not accumulating |
| pre_op | input | 2 | Pre-adder function |
| bypass | input | 1 | Route x_in around the multiplier |
| acc_en | input | 1 | Use the result register as second addend |
| sub | input | 1 | Subtract M from Z |
| logic_en | input | 1 | Select the logic unit output |
| lfn | input | 4 | Logic function code |
| simd | input | 2 | Lane split |
| pattern | input | 48 | Pattern for the comparator |
| mask | input | 48 | Don't-care bits for the comparator |
| p_out | output | 48 | Result register |
| carry_out | output | 4 | Per-lane carry outputs |
| pat_hit | output | 1 | Pattern match flag |
| pat_inv_hit | output | 1 | Inverted-pattern match flag |

## Verification
Several operand sets are chosen so that every lane overflows at the same time. A design that leaked a carry across a lane boundary would then corrupt the low bit of the next lane, and a design that reported carries on bits that do not end a lane would raise spurious carry_out bits. Subtraction of equal and of larger operands checks the no-borrow sense of the carry. Pre-adder sums that overflow 27 bits catch a pre-adder built wider than the multiplier port. All sixteen logic codes are applied, including the undefined ones that must give zero. Runs of cycles with the clock enable dropped, and a reset asserted while the enable is low, expose a design that lets an accumulating result or a stale flag slip past the freeze, or that gates reset with the enable.

// File: rtl/mac_slice.sv
module mac_slice #(
  parameter int AW = 27,
  parameter int BW = 18,
  parameter int DW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [AW-1:0] a_in,
  input  logic [AW-1:0] d_in,
  input  logic [BW-1:0] b_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic [1:0]    pre_op,
  input  logic          bypass,
  input  logic          acc_en,
  input  logic          sub,
  input  logic          logic_en,
  input  logic [3:0]    lfn,
  input  logic [1:0]    simd,
  input  logic [DW-1:0] pattern,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] p_out,
  output logic [3:0]    carry_out,
  output logic          pat_hit,
  output logic          pat_inv_hit
);
  localparam int NSEG = 4;
  localparam int SW   = DW / NSEG;
  localparam int PW   = AW + BW;

  logic signed [AW-1:0] a_q, d_q;
  logic signed [BW-1:0] b_q;
  logic [DW-1:0] x_q, y_q;
  logic [1:0]    pre_q, simd_q;
  logic [3:0]    lfn_q;
  logic          byp_q, acc_q, sub_q, log_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; d_q <= '0; b_q <= '0; x_q <= '0; y_q <= '0;
      pre_q <= '0; simd_q <= '0; lfn_q <= '0;
      byp_q <= 1'b0; acc_q <= 1'b0; sub_q <= 1'b0; log_q <= 1'b0;
    end else if (ce) begin
      a_q <= a_in; d_q <= d_in; b_q <= b_in; x_q <= x_in; y_q <= y_in;
      pre_q <= pre_op; simd_q <= simd; lfn_q <= lfn;
      byp_q <= bypass; acc_q <= acc_en; sub_q <= sub; log_q <= logic_en;
    end
  end

  logic signed [AW-1:0] pre_v;
  always_comb begin
    case (pre_q)
      2'd1:    pre_v = a_q + d_q;
      2'd2:    pre_v = a_q - d_q;
      default: pre_v = a_q;
    endcase
  end

  logic signed [PW-1:0] prod;
  assign prod = pre_v * b_q;

  logic [DW-1:0] m, z, mx, sum, lg, res;
  assign m  = byp_q ? x_q : {{(DW-PW){prod[PW-1]}}, prod};
  assign z  = acc_q ? p_out : y_q;
  assign mx = sub_q ? ~m : m;

  logic [3:0] spl;
  assign spl = (simd_q == 2'd1) ? 4'(NSEG/2) : (simd_q == 2'd2) ? 4'd1 : 4'(NSEG);

  logic [NSEG-1:0] seg_start, lane_end, cin, cout;
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign seg_start[i] = ((4'(i) & (spl - 4'd1)) == 4'd0);
    assign lane_end[i]  = ((4'(i + 1) & (spl - 4'd1)) == 4'd0);
    if (i == 0) begin : g_first
      assign cin[i] = sub_q;
    end else begin : g_rest
      assign cin[i] = seg_start[i] ? sub_q : cout[i-1];
    end
    assign {cout[i], sum[i*SW +: SW]} =
      {1'b0, z[i*SW +: SW]} + {1'b0, mx[i*SW +: SW]} + {{SW{1'b0}}, cin[i]};
  end

  always_comb begin
    case (lfn_q)
      4'd0:    lg = m & z;
      4'd1:    lg = m | z;
      4'd2:    lg = m ^ z;
      4'd3:    lg = ~(m ^ z);
      4'd4:    lg = ~(m & z);
      4'd5:    lg = ~(m | z);
      4'd6:    lg = m & ~z;
      4'd7:    lg = ~m & z;
      4'd8:    lg = ~m;
      4'd9:    lg = ~z;
      default: lg = '0;
    endcase
  end

  assign res = log_q ? lg : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_out       <= '0;
      carry_out   <= '0;
      pat_hit     <= 1'b0;
      pat_inv_hit <= 1'b0;
    end else if (ce) begin
      p_out       <= res;
      carry_out   <= log_q ? 4'd0 : (cout & lane_end);
      pat_hit     <= (((p_out ^ pattern) & ~mask) == '0);
      pat_inv_hit <= (((p_out ^ ~pattern) & ~mask) == '0);
    end
  end

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(p_out) && $stable(carry_out) && $stable(pat_hit))); // R11
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ce && log_q) |=> (carry_out == 4'd0)); // R7
  AST_WIDE_LANE_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ce && !log_q && (simd_q == 2'd0 || simd_q == 2'd3)) |=> (carry_out[2:0] == 3'd0)); // R6
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
    (ce && byp_q && acc_q && !sub_q && !log_q && simd_q == 2'd0 && x_q == DW'(1))
    |=> (p_out == $past(p_out) + DW'(1))); // R10
  AST_PAT_EXCL: assert property (@(posedge clk) disable iff (rst)
    (pat_hit && pat_inv_hit && $past(ce)) |-> $past(&mask)); // R9
endmodule

// File: tb/tb_mac_slice.sv
module tb_mac_slice;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ce, bypass, acc_en, sub, logic_en;
  logic [26:0] a_in, d_in;
  logic [17:0] b_in;
  logic [47:0] x_in, y_in, pattern, mask;
  logic [1:0]  pre_op, simd;
  logic [3:0]  lfn;
  logic [47:0] p_out;
  logic [3:0]  carry_out;
  logic        pat_hit, pat_inv_hit;

  mac_slice dut (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a_in), .d_in(d_in), .b_in(b_in),
    .x_in(x_in), .y_in(y_in), .pre_op(pre_op), .bypass(bypass), .acc_en(acc_en),
    .sub(sub), .logic_en(logic_en), .lfn(lfn), .simd(simd), .pattern(pattern),
    .mask(mask), .p_out(p_out), .carry_out(carry_out), .pat_hit(pat_hit),
    .pat_inv_hit(pat_inv_hit)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R12 reset";

  // reference model state
  logic [26:0] ra, rd;
  logic [17:0] rb;
  logic [47:0] rx, ry, mp;
  logic [1:0]  rpre, rsimd;
  logic [3:0]  rlfn, mc;
  logic        rbyp, racc, rsub, rlog, mh, mi;

  function automatic void model_eval(output logic [47:0] r, output logic [3:0] c);
    longint av, dv, pv, pr, zl, ml, rr, mk;
    logic [26:0] pt;
    logic [47:0] m, z;
    int w;
    av = longint'($signed(ra));
    dv = longint'($signed(rd));
    pv = (rpre == 2'd1) ? av + dv : (rpre == 2'd2) ? av - dv : av;
    pt = pv[26:0];
    pr = longint'($signed(pt)) * longint'($signed(rb));
    m = rbyp ? rx : pr[47:0];
    z = racc ? mp : ry;
    r = '0; c = '0;
    if (rlog) begin
      case (rlfn)
        4'd0: r = m & z;    4'd1: r = m | z;     4'd2: r = m ^ z;
        4'd3: r = m ~^ z;   4'd4: r = ~(m & z);  4'd5: r = ~(m | z);
        4'd6: r = m & ~z;   4'd7: r = ~m & z;    4'd8: r = ~m;
        4'd9: r = ~z;       default: r = '0;
      endcase
    end else begin
      w = (rsimd == 2'd1) ? 24 : (rsimd == 2'd2) ? 12 : 48;
      mk = (64'sd1 <<< w) - 1;
      for (int k = 0; k < 48 / w; k++) begin
        zl = longint'({16'd0, z}) >>> (k * w) & mk;
        ml = longint'({16'd0, m}) >>> (k * w) & mk;
        rr = rsub ? zl + (~ml & mk) + 1 : zl + ml;
        r = r | 48'((rr & mk) <<< (k * w));
        c[((k + 1) * w / 12) - 1] = rr[w];
      end
    end
  endfunction

  always @(posedge clk) begin
    logic [47:0] nr;
    logic [3:0]  nc;
    if (rst) begin
      ra = '0; rd = '0; rb = '0; rx = '0; ry = '0; rpre = '0; rsimd = '0; rlfn = '0;
      rbyp = 0; racc = 0; rsub = 0; rlog = 0; mp = '0; mc = '0; mh = 0; mi = 0;
    end else if (ce) begin
      model_eval(nr, nc);
      mh = (((mp ^ pattern) & ~mask) == '0);
      mi = (((mp ^ ~pattern) & ~mask) == '0);
      mp = nr; mc = nc;
      ra = a_in; rd = d_in; rb = b_in; rx = x_in; ry = y_in; rpre = pre_op;
      rsimd = simd; rlfn = lfn; rbyp = bypass; racc = acc_en; rsub = sub; rlog = logic_en;
    end
  end

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done && tests > 0) begin
      chk({tag, " p_out"}, p_out, mp);
      chk({tag, " R7 carry_out"}, 48'(carry_out), 48'(mc));
      chk({tag, " R9 pat_hit"}, 48'(pat_hit), 48'(mh));
      chk({tag, " R9 pat_inv_hit"}, 48'(pat_inv_hit), 48'(mi));
    end
  end

  task automatic rnd_ops();
    a_in = 27'($urandom()); d_in = 27'($urandom()); b_in = 18'($urandom());
    x_in = 48'({$urandom(), $urandom()}); y_in = 48'({$urandom(), $urandom()});
  endtask

  task automatic run(string t, int n, bit [1:0] pre, bit byp, bit acc, bit sb, bit [1:0] sm);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rnd_ops();
      pre_op = (pre == 2'd3) ? 2'($urandom()) : pre;
      bypass = byp; acc_en = acc; sub = sb; simd = sm; logic_en = 0;
    end
  endtask

  initial begin
    rst = 1; ce = 1; a_in = '0; d_in = '0; b_in = '0; x_in = '0; y_in = '0;
    pre_op = '0; bypass = 0; acc_en = 0; sub = 0; logic_en = 0; lfn = '0; simd = '0;
    pattern = 48'h0000_0000_0001; mask = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset p_out", p_out, 48'd0);
    chk("R12 reset carry", 48'(carry_out), 48'd0);
    chk("R12 reset flags", 48'({pat_hit, pat_inv_hit}), 48'd0);

    // R10 counter: from reset, p_out rises by one per edge after the pipeline fills
    @(negedge clk);
    rst = 0; bypass = 1; acc_en = 1; x_in = 48'd1; tag = "R10 count up";
    repeat (10) @(negedge clk);
    ce = 0; tag = "R11 freeze";
    chk("R10 count value", p_out, 48'd9);
    repeat (3) @(negedge clk);
    chk("R11 frozen value", p_out, 48'd9);
    ce = 1; x_in = '1; tag = "R10 count down";
    repeat (6) @(negedge clk);

    run("R1 multiply", 20, 2'd0, 0, 0, 0, 2'd0);
    run("R2 preadder", 30, 2'd3, 0, 0, 0, 2'd0);
    run("R5 subtract", 20, 2'd3, 0, 0, 1, 2'd0);
    run("R4 accumulate", 20, 2'd1, 0, 1, 0, 2'd0);
    run("R4 R5 accumulate subtract", 20, 2'd2, 0, 1, 1, 2'd0);
    run("R3 bypass", 20, 2'd0, 1, 0, 0, 2'd0);
    run("R6 two lanes", 20, 2'd0, 1, 0, 0, 2'd1);
    run("R6 four lanes", 20, 2'd0, 1, 0, 1, 2'd2);
    run("R6 code three wide", 10, 2'd0, 1, 0, 0, 2'd3);
    run("R6 accumulate four lanes", 20, 2'd0, 1, 1, 0, 2'd2);

    // R7 lane corners: all-ones plus one overflows every lane; equal operands subtract with no borrow
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      tag = "R7 lane overflow"; simd = 2'(s); bypass = 1; acc_en = 0; sub = 0;
      x_in = '1; y_in = 48'h001_001_001_001;
      @(negedge clk);
      tag = "R7 borrow"; sub = 1; x_in = 48'h123_456_789_abc; y_in = 48'h123_456_789_abc;
      @(negedge clk);
      x_in = 48'h001_001_001_001; y_in = '0;
    end

    // R8 every logic code
    tag = "R8 logic";
    for (int f = 0; f < 16; f++) begin
      @(negedge clk);
      rnd_ops(); logic_en = 1; lfn = 4'(f); bypass = f[0]; acc_en = f[1]; simd = 2'(f);
    end
    @(negedge clk);
    logic_en = 0;

    // R9 pattern flags
    tag = "R9 pattern"; pattern = 48'h5a5a_1234_c3c3; mask = '0;
    bypass = 1; acc_en = 0; sub = 0; simd = 0; y_in = '0;
    @(negedge clk); x_in = pattern;
    @(negedge clk); x_in = ~pattern;
    @(negedge clk); x_in = pattern ^ 48'h0000_0000_00f0; mask = 48'h0000_0000_00ff;
    @(negedge clk); x_in = ~pattern ^ 48'h0000_0000_000f;
    @(negedge clk); mask = '1;
    @(negedge clk); x_in = pattern ^ 48'h8000_0000_0000; mask = '0;
    repeat (3) @(negedge clk);

    // R11 random enable gaps while accumulating
    tag = "R11 enable gaps";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rnd_ops(); ce = $urandom() % 3 != 0; bypass = 1; acc_en = 1; sub = i[0]; simd = 2'(i);
      pattern = x_in; mask = 48'hffff_ffff_0000;
    end

    // R12 reset wins over a low enable
    @(negedge clk);
    tag = "R12 reset with ce low"; ce = 0; rst = 1;
    @(negedge clk);
    chk("R12 reset under ce=0", p_out, 48'd0);
    rst = 0; ce = 1;
    run("R1 after reset", 10, 2'd3, 0, 1, 0, 2'd0);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule